// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides whether the local device is being addressed on an I2C bus. It sits behind a bit-level receiver that already turns SCL/SDA activity into decoded events: a START (or repeated START) pulse, a STOP pulse, and a strobe that carries each received byte. Only the first byte after a START is treated as an address. Its upper seven bits are compared with a programmable own address. A match raises a one-cycle hit pulse, holds an "addressed" level until the frame ends, and captures the direction bit.

The block also watches for the general call address, which is seven zero bits followed by a write direction. When it sees one, it sets a sticky flag. Software can clear that flag only in two steps: it must first read the flag while it is 1, and then write 0 to it. A format-select bit in the configuration register switches the block to clock synchronous serial format. In that format all address handling is off.

Top module: `slave_addr_recognizer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, which means own address 0 and I2C format. `addr_hit`, `addressed`, `rw_bit` and `gc_flag` are all 0.
- R2: A `cfg_wr` pulse loads `cfg_wdata[7:1]` as the own address and `cfg_wdata[0]` as the format select (0 = I2C, 1 = clock synchronous serial). The new value reads back on `cfg_rdata` from the next cycle.
- R3: In I2C format, suppose the first byte after a START has bits [7:1] equal to the own address. Then `addr_hit` is 1 for exactly the one cycle after the byte strobe. `addressed` goes to 1 in the same cycle, and `rw_bit` takes byte bit [0].
- R4: A first byte whose bits [7:1] differ from the own address produces no `addr_hit`. It leaves `addressed` at 0 and leaves `rw_bit` unchanged.
- R5: Bytes that arrive after the first byte of a frame are never compared, up to the next START.
- R6: A STOP or a new START clears `addressed` in the next cycle. Bytes that arrive after a STOP without a new START are ignored.
- R7: With format select = 1, no byte raises `addr_hit` or `addressed`, and no byte sets `gc_flag`.
- R8: In I2C format, a first byte of 0x00 sets `gc_flag` from the next cycle. A first byte of 0x01 does not set it.
- R9: A `gc_rd` while `gc_flag` = 1 arms the clear. A later `gc_wr` with `gc_wdata` = 0 then clears the flag. Three things have no effect on the flag: a write of 0 without that prior read, a write of 1, and a read made while the flag is 0.
- R10: If the flag is set in the same cycle as a clearing write, the flag stays 1 and the arm is dropped. A further write of 0 then has no effect until the flag is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_start | input | 1 | One-cycle pulse for a START or repeated START |
| bus_stop | input | 1 | One-cycle pulse for a STOP |
| byte_valid | input | 1 | One-cycle strobe, received byte present on `byte_data` |
| byte_data | input | 8 | Received byte, bit 0 is the last bit on the wire |
| cfg_wr | input | 1 | Write strobe for the address/format register |
| cfg_wdata | input | 8 | [7:1] own address, [0] format select |
| gc_rd | input | 1 | Software read of the general call flag |
| gc_wr | input | 1 | Software write of the general call flag |
| gc_wdata | input | 1 | Value written to the general call flag |
| cfg_rdata | output | 8 | Current address/format register |
| addr_hit | output | 1 | One-cycle pulse on own-address match |
| addressed | output | 1 | Level, device selected in the current frame |
| rw_bit | output | 1 | Direction bit of the last matching address byte |
| gc_flag | output | 1 | Sticky general call flag |

## Verification
Suppose the frame tracker loses its state. A stale "expecting address" state shows up as a spurious `addr_hit` or `gc_flag` on a data byte, one cycle after that byte's strobe. A stuck "data" state shows up as a missing hit on the next address byte. A wrong arm bit shows up only at the ports, one cycle after a software write of 0, as a flag that clears when it should hold, or holds when it should clear. For this reason each flag scenario ends with a write followed by a flag check. The address sweep pairs many own addresses with every possible first byte, so any compare-bit fault shows up as a miscompare within one cycle of the strobe.

// File: rtl/slave_addr_pkg.sv
// Package: shared types for the slave address recognizer.
// Assumes: frame state is one of three phases between bus conditions.
package slave_addr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no frame, or frame ended by STOP
        PH_ADDR = 2'd1,   // START seen, next byte is the address
        PH_DATA = 2'd2    // address consumed, bytes are payload
    } frame_phase_e;
endpackage

// File: rtl/sar_cfg_reg.sv
// Module: sar_cfg_reg
// Holds the own address and the format-select bit, written as one word.
// Assumes: word bit 0 is format select, upper bits are the address.
module sar_cfg_reg #(
    parameter int ADDR_W = 7,
    localparam int WORD_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] own_addr,
    output logic              fmt_sync
);
    logic [WORD_W-1:0] word_q;

    // Load the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (wr_en) word_q <= wr_word;
    end

    assign rd_word  = word_q;
    assign own_addr = word_q[WORD_W-1:1];
    assign fmt_sync = word_q[0];
endmodule

// File: rtl/frame_tracker.sv
// Module: frame_tracker
// Follows START/STOP and byte strobes, and flags the first byte of a frame.
// Assumes: STOP has priority over START in the same cycle.
module frame_tracker
    import slave_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic byte_valid,
    output logic first_byte
);
    frame_phase_e phase_q, phase_d;

    // Next phase from bus events.
    always_comb begin
        phase_d = phase_q;
        if (bus_stop)                              phase_d = PH_IDLE;
        else if (bus_start)                        phase_d = PH_ADDR;
        else if (byte_valid && phase_q == PH_ADDR) phase_d = PH_DATA;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign first_byte = byte_valid && (phase_q == PH_ADDR) && !bus_start && !bus_stop;
endmodule

// File: rtl/addr_compare.sv
// Module: addr_compare
// Compares an address byte with the own address, and decodes a general call.
// Assumes: first_byte is asserted only for the address byte of a frame.
module addr_compare #(
    parameter int ADDR_W = 7,
    localparam int WORD_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_byte,
    input  logic [WORD_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              fmt_sync,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              addr_hit,
    output logic              addressed,
    output logic              rw_bit,
    output logic              gc_seen
);
    logic [ADDR_W-1:0] bit_eq;
    logic              match;
    logic              i2c_mode;

    // Per-bit equality between received address and own address.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
        assign bit_eq[i] = ~(byte_data[i+1] ^ own_addr[i]);
    end

    assign i2c_mode = !fmt_sync;
    assign match    = first_byte && i2c_mode && (&bit_eq);
    assign gc_seen  = first_byte && i2c_mode && (byte_data == '0);

    // Hit pulse, selection level and direction capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hit  <= 1'b0;
            addressed <= 1'b0;
            rw_bit    <= 1'b0;
        end else begin
            addr_hit <= match;
            if (bus_stop || bus_start) addressed <= 1'b0;
            else if (match)            addressed <= 1'b1;
            if (match) rw_bit <= byte_data[0];
        end
    end
endmodule

// File: rtl/gc_sticky.sv
// Module: gc_sticky
// Sticky general call flag, cleared by a 0 write only after it was read as 1.
// Assumes: a set in the same cycle as a clear wins, and the arm is dropped.
module gc_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr_req;

    assign clr_req = wr_i && !wdata_i && armed_q;

    // Flag and arm update: set wins over clear, a read while set arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (clr_req) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/slave_addr_recognizer.sv
// Module: slave_addr_recognizer (top)
// Recognizes the own address and the general call in the first byte after START.
// Assumes: bus events are decoded, single-cycle, and synchronous to clk.
module slave_addr_recognizer #(
    parameter int ADDR_W = 7,
    localparam int WORD_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_valid,
    input  logic [WORD_W-1:0] byte_data,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              gc_rd,
    input  logic              gc_wr,
    input  logic              gc_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              addr_hit,
    output logic              addressed,
    output logic              rw_bit,
    output logic              gc_flag
);
    logic [ADDR_W-1:0] own_addr;
    logic              fmt_sync;
    logic              first_byte;
    logic              gc_seen;

    sar_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_word  (cfg_wdata),
        .rd_word  (cfg_rdata),
        .own_addr (own_addr),
        .fmt_sync (fmt_sync)
    );

    frame_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .byte_valid (byte_valid),
        .first_byte (first_byte)
    );

    addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_byte (first_byte),
        .byte_data  (byte_data),
        .own_addr   (own_addr),
        .fmt_sync   (fmt_sync),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .addr_hit   (addr_hit),
        .addressed  (addressed),
        .rw_bit     (rw_bit),
        .gc_seen    (gc_seen)
    );

    gc_sticky u_gc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (gc_seen),
        .rd_i    (gc_rd),
        .wr_i    (gc_wr),
        .wdata_i (gc_wdata),
        .flag_o  (gc_flag)
    );
endmodule

// File: rtl/slave_addr_recognizer_chk.sv
// Module: slave_addr_recognizer_chk
// Port-level temporal checks, bound to the top module.
// Assumes: the same port names as the top module.
module slave_addr_recognizer_chk #(
    parameter int ADDR_W = 7,
    localparam int WORD_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              byte_valid,
    input logic [WORD_W-1:0] byte_data,
    input logic              cfg_wr,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              gc_rd,
    input logic              gc_wr,
    input logic              gc_wdata,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              addr_hit,
    input logic              addressed,
    input logic              rw_bit,
    input logic              gc_flag
);
    // R3
    hit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> !addr_hit);
    // R3
    hit_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> $past(byte_valid) && addressed);
    // R7
    hit_needs_i2c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> !$past(cfg_rdata[0]));
    // R6
    stop_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !addressed);
    // R8
    gc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> $past(byte_valid) && ($past(byte_data) == '0));
    // R9
    gc_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gc_flag) |-> $past(gc_wr) && !$past(gc_wdata));
endmodule

bind slave_addr_recognizer slave_addr_recognizer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/slave_addr_recognizer_bench.sv
module slave_addr_recognizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       gc_rd = 1'b0, gc_wr = 1'b0, gc_wdata = 1'b0;
    logic [7:0] cfg_rdata;
    logic       addr_hit, addressed, rw_bit, gc_flag;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    logic exp_rw = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_addr_recognizer u_slave_addr_recognizer (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .gc_rd(gc_rd), .gc_wr(gc_wr), .gc_wdata(gc_wdata),
        .cfg_rdata(cfg_rdata), .addr_hit(addr_hit), .addressed(addressed),
        .rw_bit(rw_bit), .gc_flag(gc_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] w);
        @(negedge clk) cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    // Present a byte, return at the negedge after the sampling edge.
    task automatic put_byte(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b;
        @(negedge clk) byte_valid = 1'b0;
    endtask

    task automatic gc_read();
        @(negedge clk) gc_rd = 1'b1;
        @(negedge clk) gc_rd = 1'b0;
    endtask

    task automatic gc_write(input logic v);
        @(negedge clk) gc_wr = 1'b1; gc_wdata = v;
        @(negedge clk) gc_wr = 1'b0;
    endtask

    task automatic gc_clear();
        gc_read();
        gc_write(1'b0);
    endtask

    // Address frame with model-based expectations.
    task automatic addr_frame(input logic [6:0] oa, input logic sync, input logic [7:0] b);
        logic hit;
        logic gc;
        hit = !sync && (b[7:1] == oa);
        gc  = !sync && (b == 8'h00);
        if (hit) exp_rw = b[0];
        pulse_start();
        put_byte(b);
        if (hit) chk("R3 addr_hit", addr_hit, 1);
        else     chk(sync ? "R7 addr_hit" : "R4 addr_hit", addr_hit, 0);
        chk(hit ? "R3 addressed" : "R4 addressed", addressed, hit);
        chk(hit ? "R3 rw_bit" : "R4 rw_bit", rw_bit, exp_rw);
        chk(sync ? "R7 gc_flag" : "R8 gc_flag", gc_flag, gc);
        @(negedge clk);
        chk("R3 pulse width", addr_hit, 0);
        if (gc) begin
            gc_clear();
            chk("R9 clear after read", gc_flag, 0);
        end
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 addr_hit", addr_hit, 0);
        chk("R1 addressed", addressed, 0);
        chk("R1 rw_bit", rw_bit, 0);
        chk("R1 gc_flag", gc_flag, 0);

        // R2 register readback for every own address
        for (int a = 0; a < 128; a++) begin
            cfg_write({a[6:0], 1'b0});
            chk("R2 readback", cfg_rdata, a * 2);
        end

        // R3/R4/R8 sweep: selected own addresses against every first byte
        for (int a = 0; a < 128; a += 9) begin
            cfg_write({a[6:0], 1'b0});
            for (int b = 0; b < 256; b++) addr_frame(a[6:0], 1'b0, b[7:0]);
        end
        // R3 every own address with its own read and write byte
        for (int a = 0; a < 128; a++) begin
            cfg_write({a[6:0], 1'b0});
            addr_frame(a[6:0], 1'b0, {a[6:0], 1'b1});
            addr_frame(a[6:0], 1'b0, {a[6:0], 1'b0});
        end

        // R7 synchronous format: no byte recognized
        for (int b = 0; b < 256; b++) begin
            cfg_write({7'h2A, 1'b1});
            addr_frame(7'h2A, 1'b1, b[7:0]);
        end

        // R5 later bytes never compared
        cfg_write({7'h2A, 1'b0});
        pulse_start();
        put_byte(8'h10);
        chk("R5 first miss", addr_hit, 0);
        put_byte({7'h2A, 1'b0});
        chk("R5 second byte own", addr_hit, 0);
        chk("R5 second byte addressed", addressed, 0);
        put_byte(8'h00);
        chk("R5 second byte gc", gc_flag, 0);

        // R6 STOP clears selection; bytes after STOP ignored
        pulse_start();
        put_byte({7'h2A, 1'b1});
        chk("R6 selected", addressed, 1);
        pulse_stop();
        chk("R6 stop deselect", addressed, 0);
        put_byte({7'h2A, 1'b1});
        chk("R6 byte after stop", addr_hit, 0);
        put_byte(8'h00);
        chk("R6 gc after stop", gc_flag, 0);
        // R6 repeated START clears selection
        pulse_start();
        put_byte({7'h2A, 1'b0});
        chk("R6 reselect", addressed, 1);
        pulse_start();
        chk("R6 restart deselect", addressed, 0);
        put_byte(8'h44);

        // R8 general call with read direction does not set
        pulse_start();
        put_byte(8'h01);
        @(negedge clk);
        chk("R8 0x01 no gc", gc_flag, 0);

        // R9 write rules
        pulse_start();
        put_byte(8'h00);
        chk("R8 gc set", gc_flag, 1);
        gc_write(1'b0);
        chk("R9 write0 without read", gc_flag, 1);
        gc_read();
        gc_write(1'b1);
        chk("R9 write1 no effect", gc_flag, 1);
        gc_write(1'b0);
        chk("R9 armed clear", gc_flag, 0);
        gc_read();
        pulse_start();
        put_byte(8'h00);
        gc_write(1'b0);
        chk("R9 read while 0 no arm", gc_flag, 1);

        // R10 set and clear in the same cycle
        gc_read();
        pulse_start();
        gc_wr = 1'b1; gc_wdata = 1'b0;
        put_byte(8'h00);
        gc_wr = 1'b0;
        chk("R10 set wins", gc_flag, 1);
        gc_write(1'b0);
        chk("R10 arm dropped", gc_flag, 1);
        gc_clear();
        chk("R10 rearm clears", gc_flag, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule